// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block turns an asynchronous serial line into a stream of 12-bit receive entries. Each entry carries the received character in its low byte and four status flags above it, so a downstream FIFO can keep the error status of every character next to the character itself. Word length, parity mode and stop-bit count are configuration inputs. Timing comes from an external oversampling enable that pulses sixteen times per bit period. The receiver therefore follows any bit rate the divider produces, including rates of several Mbit/s.

Finished entries are offered on a valid/ready handshake. A separate level output flags a receive time-out: unread data is waiting downstream and the line has carried no new start bit for 32 bit periods. A line held low through the whole frame is reported once as a break. The receiver then waits for the line to return high before it looks for the next start bit.

Top module: `uart_frame_rx`

## Requirements
- R1: `cfg_wlen` selects 5 + `cfg_wlen` data bits (0 gives 5 bits, 3 gives 8 bits). Bits arrive least significant first and land right-aligned in entry bits [7:0]. Entry bits above the word length read zero.
- R2: With `cfg_par_en`=1 and `cfg_par_stick`=0, the parity bit must make the count of ones over data plus parity even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. A mismatch sets entry bit 9.
- R3: With `cfg_par_en`=1 and `cfg_par_stick`=1, the parity bit must equal `cfg_par_odd` (1 when odd-select is set, 0 otherwise). Any other value sets entry bit 9.
- R4: If the first stop bit samples low in a frame that is not a break, entry bit 8 is set.
- R5: With `cfg_two_stop`=1 the second stop bit is not checked: a low level there sets no error flag.
- R6: If every data bit, the parity bit (when enabled) and the first stop bit sample low, exactly one entry of value 0x400 is delivered (data zero, only bit 10 set). No new frame starts until the line has been seen high.
- R7: `rx_valid` stays high with `rx_data` unchanged until a cycle with `rx_ready` high accepts the entry.
- R8: A frame that completes while the previous entry is still unaccepted replaces it and sets entry bit 11.
- R9: With `data_pending` high and the receiver idle, `rx_timeout` rises on the 512th oversampling tick (32 bit periods) since the count restarted. The count restarts while `data_pending` is low. The flag clears when a start bit is detected.
- R10: A start bit is confirmed by a low sample at mid-bit (eight ticks after detection). A shorter low pulse produces no entry, and each later bit is sampled sixteen ticks after the previous one.
- R11: After reset, `rx_valid` and `rx_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_line | input | 1 | Serial input, idle high |
| cfg_wlen | input | 2 | Word length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity / stick-one select |
| cfg_par_stick | input | 1 | Stick parity mode |
| cfg_two_stop | input | 1 | Two stop bits |
| data_pending | input | 1 | Downstream holds unread data |
| rx_ready | input | 1 | Consumer accepts the entry |
| rx_valid | output | 1 | Entry available |
| rx_data | output | 12 | {overrun, break, parity err, framing err, data[7:0]} |
| rx_timeout | output | 1 | Idle receive time-out flag |

## Verification
The hardest states to reach are those that depend on timing between frames. An overrun needs a second frame to finish while the first entry is still held. A break needs the line to stay low through the stop bit and then to be released without starting a spurious frame. The time-out needs an exact count of idle ticks. The bench drives every oversampling tick itself, so it knows the tick on which each sample and each counter step falls. It holds `rx_ready` low across two frames to force the overrun. For the time-out it checks the flag one tick before and one tick after the 32-bit-period boundary.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2, ST_WAIT
  } rx_state_t;

  typedef struct packed {
    logic              ovr;
    logic              brk;
    logic              perr;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      os_tick,
  input  logic      rx,
  input  logic [1:0] cfg_wlen,
  input  logic      cfg_par_en,
  input  logic      cfg_par_odd,
  input  logic      cfg_par_stick,
  input  logic      cfg_two_stop,
  output logic      start_det,
  output logic      line_idle,
  output logic      frame_done,
  output rx_entry_t frame_entry
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_t         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              done_q, done_d;
  rx_entry_t         entry_q, entry_d, built;

  logic [DATA_W-1:0] data_al;
  logic              sum, brk;

  // assemble the entry from the current shift state and the stop sample
  always_comb begin
    data_al = sh_q >> (2'd3 - cfg_wlen);
    sum     = (^data_al) ^ par_q;
    brk     = (data_al == '0) && (!cfg_par_en || !par_q) && !rx;
    built.ovr  = 1'b0;
    built.brk  = brk;
    built.data = data_al;
    built.ferr = !rx && !brk;
    built.perr = !brk && cfg_par_en &&
                 (cfg_par_stick ? (par_q != cfg_par_odd) : (sum != cfg_par_odd));
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    par_d   = par_q;
    done_d  = 1'b0;
    entry_d = entry_q;
    case (state_q)
      ST_IDLE: if (os_tick && !rx) begin
        state_d = ST_START;
        cnt_d   = '0;
      end
      ST_START: if (os_tick) begin
        if (cnt_q == MID) begin
          cnt_d = '0;
          if (!rx) begin
            state_d = ST_DATA;
            bit_d   = '0;
            sh_d    = '0;
          end else begin
            state_d = ST_IDLE;
          end
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_DATA: if (os_tick) begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          sh_d  = {rx, sh_q[DATA_W-1:1]};
          bit_d = bit_q + 3'd1;
          if (bit_q == {1'b1, cfg_wlen}) state_d = cfg_par_en ? ST_PAR : ST_STOP;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_PAR: if (os_tick) begin
        if (cnt_q == LAST) begin
          cnt_d   = '0;
          par_d   = rx;
          state_d = ST_STOP;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_STOP: if (os_tick) begin
        if (cnt_q == LAST) begin
          cnt_d   = '0;
          done_d  = 1'b1;
          entry_d = built;
          state_d = cfg_two_stop ? ST_STOP2 : ST_WAIT;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_STOP2: if (os_tick) begin
        if (cnt_q == LAST) begin
          cnt_d   = '0;
          state_d = ST_WAIT;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_WAIT: if (rx) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
      entry_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      done_q  <= done_d;
      entry_q <= entry_d;
    end
  end

  assign start_det   = (state_q == ST_IDLE) && os_tick && !rx;
  assign line_idle   = (state_q == ST_IDLE);
  assign frame_done  = done_q;
  assign frame_entry = entry_q;

  // R6
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10
  start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && state_d == ST_DATA) |-> (os_tick && !rx));
endmodule

// File: rtl/uart_rx_idle_timer.sv
module uart_rx_idle_timer #(
  parameter int OSR     = 16,
  parameter int TO_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic line_idle,
  input  logic start_det,
  input  logic data_pending,
  output logic timeout
);
  localparam int LIMIT = OSR * TO_BITS;
  localparam int TW    = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          step;

  always_comb begin
    step   = os_tick && line_idle && data_pending && !flag_q;
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (start_det || !data_pending) cnt_d = '0;
    else if (step)                  cnt_d = cnt_q + 1'b1;
    if (start_det)                      flag_d = 1'b0;
    else if (step && (cnt_q == LAST))   flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign timeout = flag_q;

  // R9
  to_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(data_pending));

  // R9
  to_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(LIMIT));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int TO_BITS   = 32,
  parameter int SYNC_STG  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        rx_line,
  input  logic [1:0]  cfg_wlen,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic        cfg_par_stick,
  input  logic        cfg_two_stop,
  input  logic        data_pending,
  input  logic        rx_ready,
  output logic        rx_valid,
  output logic [11:0] rx_data,
  output logic        rx_timeout
);
  logic      rx_s, start_det, line_idle, frame_done;
  rx_entry_t fr_entry, out_q, out_d;
  logic      valid_q, valid_d;

  uart_rx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
  );

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx(rx_s),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_par_stick(cfg_par_stick), .cfg_two_stop(cfg_two_stop),
    .start_det(start_det), .line_idle(line_idle),
    .frame_done(frame_done), .frame_entry(fr_entry)
  );

  uart_rx_idle_timer #(.OSR(OSR), .TO_BITS(TO_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_idle(line_idle),
    .start_det(start_det), .data_pending(data_pending), .timeout(rx_timeout)
  );

  always_comb begin
    valid_d = valid_q;
    out_d   = out_q;
    if (valid_q && rx_ready) valid_d = 1'b0;
    if (frame_done) begin
      valid_d   = 1'b1;
      out_d     = fr_entry;
      out_d.ovr = valid_q && !rx_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= valid_d;
      out_q   <= out_d;
    end
  end

  assign rx_valid = valid_q;
  assign rx_data  = out_q;

  // R7
  hold_until_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R7
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !frame_done) |=> $stable(rx_data));

  // R6
  break_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_data[10]) |-> (rx_data[9:0] == 10'd0));

  // R8
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_valid && !rx_ready) |=> rx_data[11]);
endmodule

// File: tb/uart_frame_rx_test.sv
`timescale 1ns/1ps
module uart_frame_rx_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        os_tick, rx_line;
  logic [1:0]  cfg_wlen;
  logic        cfg_par_en, cfg_par_odd, cfg_par_stick, cfg_two_stop;
  logic        data_pending, rx_ready;
  logic        rx_valid, rx_timeout;
  logic [11:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_par_stick(cfg_par_stick), .cfg_two_stop(cfg_two_stop),
    .data_pending(data_pending), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_timeout(rx_timeout)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    tick_n(16);
  endtask

  function automatic logic [7:0] mask_data(input logic [7:0] d, input logic [1:0] wl);
    return d & (8'hFF >> (3 - wl));
  endfunction

  function automatic logic good_parity(input logic [7:0] dm);
    if (cfg_par_stick) return cfg_par_odd;
    return (^dm) ^ cfg_par_odd;
  endfunction

  // sends one frame with the current config and returns the expected entry (no overrun bit)
  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop1_low,
                            input bit stop2_low, output logic [11:0] exp);
    logic [7:0] dm;
    logic       pb;
    bit         brk;
    dm = mask_data(d, cfg_wlen);
    pb = good_parity(dm) ^ bad_par;
    send_bit(1'b0);
    for (int i = 0; i < 5 + int'(cfg_wlen); i++) send_bit(dm[i]);
    if (cfg_par_en) send_bit(pb);
    send_bit(!stop1_low);
    if (cfg_two_stop) send_bit(!stop2_low);
    rx_line = 1'b1;
    tick_n(20);
    brk = (dm == 8'h00) && (!cfg_par_en || !pb) && stop1_low;
    if (brk) exp = 12'h400;
    else     exp = {2'b00, cfg_par_en && bad_par, stop1_low, dm};
  endtask

  task automatic accept(input string req);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
    check(req, {11'd0, rx_valid}, 12'd0);
  endtask

  task automatic set_cfg(input logic [1:0] wl, input bit pe, input bit po,
                         input bit ps, input bit ts);
    cfg_wlen = wl; cfg_par_en = pe; cfg_par_odd = po;
    cfg_par_stick = ps; cfg_two_stop = ts;
  endtask

  task automatic frame_and_check(input string req, input logic [7:0] d, input bit bp,
                                 input bit s1, input bit s2);
    logic [11:0] exp;
    send_frame(d, bp, s1, s2, exp);
    check(req, {11'd0, rx_valid}, 12'd1);
    check(req, rx_data, exp);
    accept(req);
  endtask

  initial begin
    logic [11:0] e1, e2;
    void'($urandom(32'd2024));
    rst_n = 1'b0; os_tick = 1'b0; rx_line = 1'b1; rx_ready = 1'b0;
    data_pending = 1'b0;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", {11'd0, rx_valid}, 12'd0);
    check("R11", {11'd0, rx_timeout}, 12'd0);

    // R10 short low pulse rejected
    rx_line = 1'b0; tick_n(3); rx_line = 1'b1; tick_n(40);
    check("R10", {11'd0, rx_valid}, 12'd0);

    // R1 word lengths, LSB first
    set_cfg(2'd3, 0, 0, 0, 0); frame_and_check("R1", 8'hA5, 0, 0, 0);
    set_cfg(2'd0, 0, 0, 0, 0); frame_and_check("R1", 8'hFF, 0, 0, 0);
    set_cfg(2'd2, 0, 0, 0, 0); frame_and_check("R1", 8'h5A, 0, 0, 0);

    // R2 normal parity, good and bad
    set_cfg(2'd3, 1, 0, 0, 0); frame_and_check("R2", 8'h37, 0, 0, 0);
    set_cfg(2'd3, 1, 1, 0, 0); frame_and_check("R2", 8'h37, 1, 0, 0);
    set_cfg(2'd1, 1, 0, 0, 0); frame_and_check("R2", 8'h2C, 1, 0, 0);

    // R3 stick parity
    set_cfg(2'd3, 1, 1, 1, 0); frame_and_check("R3", 8'h81, 0, 0, 0);
    set_cfg(2'd3, 1, 0, 1, 0); frame_and_check("R3", 8'h81, 1, 0, 0);

    // R4 framing error
    set_cfg(2'd3, 0, 0, 0, 0); frame_and_check("R4", 8'h3C, 0, 1, 0);

    // R5 second stop bit low is ignored
    set_cfg(2'd3, 1, 0, 0, 1); frame_and_check("R5", 8'hC3, 0, 0, 1);

    // R6 break: line low throughout, held low longer, single entry
    set_cfg(2'd3, 1, 0, 0, 0);
    rx_line = 1'b0; tick_n(16 * 14);
    rx_line = 1'b1; tick_n(20);
    check("R6", {11'd0, rx_valid}, 12'd1);
    check("R6", rx_data, 12'h400);
    accept("R6");
    tick_n(40);
    check("R6", {11'd0, rx_valid}, 12'd0);

    // R7 entry held while not accepted, R8 overrun on second frame
    set_cfg(2'd3, 0, 0, 0, 0);
    send_frame(8'h11, 0, 0, 0, e1);
    tick_n(48);
    check("R7", {11'd0, rx_valid}, 12'd1);
    check("R7", rx_data, e1);
    send_frame(8'h22, 0, 0, 0, e2);
    check("R8", rx_data, e2 | 12'h800);
    accept("R8");
    frame_and_check("R8", 8'h33, 0, 0, 0);

    // R9 idle time-out boundary and clearing
    data_pending = 1'b0; @(negedge clk);
    data_pending = 1'b1;
    tick_n(511);
    check("R9", {11'd0, rx_timeout}, 12'd0);
    tick_n(1);
    check("R9", {11'd0, rx_timeout}, 12'd1);
    send_frame(8'h44, 0, 0, 0, e1);
    check("R9", {11'd0, rx_timeout}, 12'd0);
    check("R9", rx_data, e1);
    accept("R9");
    data_pending = 1'b0;

    // random frames across all modes
    for (int n = 0; n < 40; n++) begin
      set_cfg(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      frame_and_check("R1-random", 8'($urandom), ($urandom_range(0, 4) == 0),
                      ($urandom_range(0, 5) == 0), ($urandom_range(0, 1) == 1));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule